// File: doc/BRIEF.md
# LED Blink and Ramp Sequencer

This block sits between a bank of LED current-source registers and the current sources themselves. For each of eighteen channels it takes a programmed current code and a two-bit mode. From these it produces the effective code that the current source should drive at that moment. A channel can hold its code steady, flash it on and off, or sweep it smoothly between zero and the programmed value. Each channel uses exactly one of these behaviours at a time. One shared control word sets the blink on-time, the blink period, the ramp duration and the ramp direction. The blink settings and the ramp settings are chosen separately.

All timing is counted in ticks of a single prescaler. The prescaler divides the system clock, set by `CLK_HZ`, down to a tick rate, set by `TICK_HZ`, which is 4 kHz by default. A simulation can therefore run with a scaled-down clock and the same tick counts. Each channel has its own state machine. The states are `ST_HOLD`, `ST_BLINK_ON`, `ST_BLINK_OFF`, `ST_RAMP` and `ST_RAMP_DONE`. The transitions are:

- *restart*: any state moves to the state that matches the new mode, with the phase counter cleared.
- *on-expire*: `ST_BLINK_ON` moves to `ST_BLINK_OFF`.
- *period-expire*: `ST_BLINK_OFF` moves to `ST_BLINK_ON`.
- *endpoint*: `ST_RAMP` moves to `ST_RAMP_DONE`.

When a downward sweep ends, the block pulses a request that returns the charge pump to 1x.

Top module: `led_blink_ramp_seq`

## Requirements
- R1: While reset is held, and right after it is released with all modes steady, every `eff_o` field equals its `code_i` field and `pump_1x_req_o` is 0.
- R2: A channel in mode 0 or 3 (steady, `ST_HOLD`) drives its `code_i` value on `eff_o` with no delay. Changes to the control word do not affect it.
- R3: Mode 1 (blink) starts in `ST_BLINK_ON` with `eff_o` equal to the code. The on-phase lasts 624 ticks (156 ms) when control bit 0 is 0, and 2500 ticks (625 ms) when it is 1. One tick is `CLK_HZ/TICK_HZ` clocks.
- R4: A blink period lasts 5000 ticks (1.25 s) when control bit 1 is 0, and 10000 ticks (2.5 s) when it is 1. During the rest of the period after the on-phase (`ST_BLINK_OFF`), `eff_o` is 0.
- R5: Mode 2 (ramp) changes the effective code by exactly one at each step. The step interval is the ramp time divided by 2^CODE_W. Control bits 3:2 select the ramp time: 00 selects 960 ticks (0.24 s), 01 selects 1920 ticks (0.48 s), and 10 or 11 selects 3840 ticks (0.96 s). With the default width this gives steps of 15, 30 and 60 ticks.
- R6: When control bit 4 is 1, a ramp starts at 0, rises to the programmed code and holds there in `ST_RAMP_DONE`.
- R7: When control bit 4 is 0, a ramp starts at the programmed code, falls to 0 and holds 0 in `ST_RAMP_DONE`.
- R8: `pump_1x_req_o` is high for exactly one cycle. That cycle is the first one in which a downward ramp shows 0, and several channels finishing together give one pulse.
- R9: A change of a channel's mode, or of any bit of the control word, restarts that channel's phase from zero at the next clock edge.
- R10: Channels are independent. A mode change on one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_i | input | 5 | Shared control: [0] on-time select, [1] period select, [3:2] ramp-time select, [4] ramp up |
| mode_i | input | 2*NUM_CH | Per-channel mode, channel n at [2n+1:2n]: 0/3 steady, 1 blink, 2 ramp |
| code_i | input | CODE_W*NUM_CH | Per-channel programmed current code |
| eff_o | output | CODE_W*NUM_CH | Per-channel effective current code |
| pump_1x_req_o | output | 1 | One-cycle request to return the charge pump to 1x |

## Verification
A new mode or control word is registered at the first clock edge after it is applied. The effective code of a restarted channel is therefore due one edge later: it is combinational from the state register, and it follows `code_i` at once while a channel is steady. Blink and ramp edges fall on the edge where the counted tick fires. The 1x request is registered, so it appears in the same cycle as the zero it accompanies. The bench advances a behavioural model on each rising edge and compares every output at the following falling edge. Phase lengths measured from a stimulus allow the one-tick uncertainty that the free-running prescaler introduces.

// File: rtl/led_seq_pkg.sv
package led_seq_pkg;

    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        MODE_STEADY   = 2'd0,
        MODE_BLINK    = 2'd1,
        MODE_RAMP     = 2'd2,
        MODE_STEADY_B = 2'd3
    } chan_mode_e;

    typedef enum logic [2:0] {
        ST_HOLD      = 3'd0,
        ST_BLINK_ON  = 3'd1,
        ST_BLINK_OFF = 3'd2,
        ST_RAMP      = 3'd3,
        ST_RAMP_DONE = 3'd4
    } chan_state_e;

    typedef struct packed {
        logic       ramp_up;
        logic [1:0] ramp_sel;
        logic       period_sel;
        logic       on_sel;
    } seq_ctrl_t;

    // Converts a duration in milliseconds to ticks of the given rate.
    function automatic int ms_to_ticks(input int ms, input int tick_hz);
        return (ms * tick_hz) / 1000;
    endfunction

    // Ticks between ramp steps: ramp duration over the number of codes, at least 1.
    function automatic int step_ticks(input int ms, input int tick_hz, input int code_w);
        int t;
        t = ms_to_ticks(ms, tick_hz) >> code_w;
        return (t < 1) ? 1 : t;
    endfunction

endpackage

// File: rtl/led_seq_timebase.sv
module led_seq_timebase #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 4000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
    localparam int PW  = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            logic [PW-1:0] pcnt_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pcnt_q <= '0;
                end else if (pcnt_q == PW'(DIV - 1)) begin
                    pcnt_q <= '0;
                end else begin
                    pcnt_q <= pcnt_q + PW'(1);
                end
            end

            assign tick_o = (pcnt_q == PW'(DIV - 1));

            // R3
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_nodiv
            assign tick_o = 1'b1;
        end
    endgenerate

endmodule

// File: rtl/led_seq_ctrl.sv
module led_seq_ctrl
    import led_seq_pkg::*;
#(
    parameter int CODE_W  = 6,
    parameter int CNT_W   = 14,
    parameter int TICK_HZ = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              ctrl_chg_o,
    output logic              up_now_o,
    output logic              up_q_o,
    output logic [CNT_W-1:0]  on_lim_o,
    output logic [CNT_W-1:0]  per_lim_o,
    output logic [CNT_W-1:0]  step_lim_o
);
    localparam int ON_SHORT  = ms_to_ticks(156, TICK_HZ);
    localparam int ON_LONG   = ms_to_ticks(625, TICK_HZ);
    localparam int PER_SHORT = ms_to_ticks(1250, TICK_HZ);
    localparam int PER_LONG  = ms_to_ticks(2500, TICK_HZ);
    localparam int STEP_FAST = step_ticks(240, TICK_HZ, CODE_W);
    localparam int STEP_MID  = step_ticks(480, TICK_HZ, CODE_W);
    localparam int STEP_SLOW = step_ticks(960, TICK_HZ, CODE_W);

    seq_ctrl_t ctrl_now, ctrl_q;

    assign ctrl_now = seq_ctrl_t'(ctrl_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_now;
        end
    end

    assign ctrl_chg_o = (ctrl_now != ctrl_q);
    assign up_now_o   = ctrl_now.ramp_up;
    assign up_q_o     = ctrl_q.ramp_up;
    assign on_lim_o   = ctrl_q.on_sel     ? CNT_W'(ON_LONG)  : CNT_W'(ON_SHORT);
    assign per_lim_o  = ctrl_q.period_sel ? CNT_W'(PER_LONG) : CNT_W'(PER_SHORT);

    always_comb begin
        unique case (ctrl_q.ramp_sel)
            2'b00:   step_lim_o = CNT_W'(STEP_FAST);
            2'b01:   step_lim_o = CNT_W'(STEP_MID);
            default: step_lim_o = CNT_W'(STEP_SLOW);
        endcase
    end

    // R9
    ctrl_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_chg_o |=> (ctrl_q == $past(ctrl_now)));

endmodule

// File: rtl/led_seq_chan.sv
module led_seq_chan
    import led_seq_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int CNT_W  = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              ctrl_chg_i,
    input  logic              up_now_i,
    input  logic              up_q_i,
    input  logic [CNT_W-1:0]  on_lim_i,
    input  logic [CNT_W-1:0]  per_lim_i,
    input  logic [CNT_W-1:0]  step_lim_i,
    input  logic [1:0]        mode_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] eff_o,
    output logic              done_evt_o
);
    chan_state_e        state_q, state_d;
    logic [CNT_W-1:0]   cnt_q, cnt_d, cnt_inc;
    logic [CODE_W-1:0]  level_q, level_d;
    logic [CODE_W:0]    level_up;
    logic [1:0]         mode_q;
    logic               restart;
    logic               step_hit;

    assign restart  = (mode_i != mode_q) || ctrl_chg_i;
    assign cnt_inc  = cnt_q + CNT_W'(1);
    assign step_hit = tick_i && (cnt_inc >= step_lim_i);
    assign level_up = {1'b0, level_q} + (CODE_W + 1)'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            level_q <= '0;
            mode_q  <= MODE_STEADY;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= level_d;
            mode_q  <= mode_i;
        end
    end

    // Next state
    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        level_d    = level_q;
        done_evt_o = 1'b0;
        if (restart) begin
            cnt_d = '0;
            unique case (mode_i)
                MODE_BLINK: state_d = ST_BLINK_ON;
                MODE_RAMP: begin
                    state_d = ST_RAMP;
                    level_d = up_now_i ? '0 : code_i;
                end
                default:    state_d = ST_HOLD;
            endcase
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                end
                ST_RAMP_DONE: begin
                end
                ST_BLINK_ON: begin
                    if (tick_i) begin
                        cnt_d = cnt_inc;
                        if (cnt_inc >= on_lim_i) begin
                            state_d = ST_BLINK_OFF;
                        end
                    end
                end
                ST_BLINK_OFF: begin
                    if (tick_i) begin
                        if (cnt_inc >= per_lim_i) begin
                            state_d = ST_BLINK_ON;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end
                end
                ST_RAMP: begin
                    if (step_hit) begin
                        cnt_d = '0;
                        if (up_q_i) begin
                            if (level_up >= {1'b0, code_i}) begin
                                level_d = code_i;
                                state_d = ST_RAMP_DONE;
                            end else begin
                                level_d = level_up[CODE_W-1:0];
                            end
                        end else begin
                            if (level_q <= CODE_W'(1)) begin
                                level_d    = '0;
                                state_d    = ST_RAMP_DONE;
                                done_evt_o = 1'b1;
                            end else begin
                                level_d = level_q - CODE_W'(1);
                            end
                        end
                    end else if (tick_i) begin
                        cnt_d = cnt_inc;
                    end
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_BLINK_OFF: eff_o = '0;
            ST_RAMP:      eff_o = level_q;
            ST_RAMP_DONE: eff_o = up_q_i ? code_i : '0;
            default:      eff_o = code_i;
        endcase
    end

    // R9
    restart_clears_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == '0));

    // R4
    off_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BLINK_OFF) |-> (cnt_q >= on_lim_i && cnt_q < per_lim_i));

    // R6
    ramp_up_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && up_q_i && !restart)
            |=> (level_q >= $past(level_q) || state_q == ST_RAMP_DONE));

    // R7
    ramp_down_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RAMP && !up_q_i && !restart) |=> (level_q <= $past(level_q)));

    // R8
    done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_evt_o |=> (eff_o == '0));

endmodule

// File: rtl/led_blink_ramp_seq.sv
module led_blink_ramp_seq
    import led_seq_pkg::*;
#(
    parameter int NUM_CH  = 18,
    parameter int CODE_W  = 6,
    parameter int CLK_HZ  = 100_000_000,
    parameter int TICK_HZ = 4000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CTRL_W-1:0]        ctrl_i,
    input  logic [2*NUM_CH-1:0]      mode_i,
    input  logic [CODE_W*NUM_CH-1:0] code_i,
    output logic [CODE_W*NUM_CH-1:0] eff_o,
    output logic                     pump_1x_req_o
);
    localparam int PER_LONG = ms_to_ticks(2500, TICK_HZ);
    localparam int CNT_W    = $clog2(PER_LONG + 1);

    logic             tick;
    logic             ctrl_chg, up_now, up_q;
    logic [CNT_W-1:0] on_lim, per_lim, step_lim;
    logic [NUM_CH-1:0] done_vec;
    logic [NUM_CH-1:0] zero_vec;

    led_seq_timebase #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ)
    ) u_tb (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    led_seq_ctrl #(
        .CODE_W  (CODE_W),
        .CNT_W   (CNT_W),
        .TICK_HZ (TICK_HZ)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_i     (ctrl_i),
        .ctrl_chg_o (ctrl_chg),
        .up_now_o   (up_now),
        .up_q_o     (up_q),
        .on_lim_o   (on_lim),
        .per_lim_o  (per_lim),
        .step_lim_o (step_lim)
    );

    generate
        for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
            led_seq_chan #(
                .CODE_W (CODE_W),
                .CNT_W  (CNT_W)
            ) u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .tick_i     (tick),
                .ctrl_chg_i (ctrl_chg),
                .up_now_i   (up_now),
                .up_q_i     (up_q),
                .on_lim_i   (on_lim),
                .per_lim_i  (per_lim),
                .step_lim_i (step_lim),
                .mode_i     (mode_i[2*ch +: 2]),
                .code_i     (code_i[CODE_W*ch +: CODE_W]),
                .eff_o      (eff_o[CODE_W*ch +: CODE_W]),
                .done_evt_o (done_vec[ch])
            );
            assign zero_vec[ch] = (eff_o[CODE_W*ch +: CODE_W] == '0);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pump_1x_req_o <= 1'b0;
        end else begin
            pump_1x_req_o <= |done_vec;
        end
    end

    // R8
    pump_with_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pump_1x_req_o |-> (|zero_vec));

endmodule

// File: tb/tb_led_blink_ramp_seq.sv
module tb_led_blink_ramp_seq;
    localparam int NUM_CH  = 18;
    localparam int CODE_W  = 6;
    localparam int CLK_HZ  = 8000;
    localparam int TICK_HZ = 4000;
    localparam int DIV     = CLK_HZ / TICK_HZ;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] ctrl = 5'b0;
    logic [2*NUM_CH-1:0] mode_v;
    logic [CODE_W*NUM_CH-1:0] code_v;
    logic [CODE_W*NUM_CH-1:0] eff;
    logic pump;

    int code_a [NUM_CH];
    int mode_a [NUM_CH];
    int n_chk = 0;
    int n_fail = 0;
    int pump_seen = 0;
    bit cmp_on = 1'b0;

    // behavioural reference state: 0 hold, 1 on, 2 off, 3 ramp, 4 done
    int m_st [NUM_CH];
    int m_cnt [NUM_CH];
    int m_lvl [NUM_CH];
    int m_mq [NUM_CH];
    int m_since [NUM_CH];
    int m_cq = 0;
    int m_pc = 0;
    bit m_pump = 1'b0;

    always #2.5 clk = ~clk;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            mode_v[2*c +: 2]           = 2'(mode_a[c]);
            code_v[CODE_W*c +: CODE_W] = CODE_W'(code_a[c]);
        end
    end

    led_blink_ramp_seq #(
        .NUM_CH  (NUM_CH),
        .CODE_W  (CODE_W),
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ)
    ) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_i        (ctrl),
        .mode_i        (mode_v),
        .code_i        (code_v),
        .eff_o         (eff),
        .pump_1x_req_o (pump)
    );

    function automatic int eff_of(int c);
        return int'(eff[CODE_W*c +: CODE_W]);
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                m_st[c] = 0; m_cnt[c] = 0; m_lvl[c] = 0; m_mq[c] = 0; m_since[c] = 99;
            end
            m_cq = 0; m_pc = 0; m_pump = 1'b0;
        end else begin
            bit tk;
            bit pn;
            int on_l, per_l, stp, rs;
            bit upq, upn;
            tk   = (m_pc == DIV - 1);
            m_pc = tk ? 0 : m_pc + 1;
            on_l  = (((m_cq >> 0) & 1) != 0) ? 2500 : 624;
            per_l = (((m_cq >> 1) & 1) != 0) ? 10000 : 5000;
            rs    = (m_cq >> 2) & 3;
            stp   = (rs == 0) ? 15 : (rs == 1) ? 30 : 60;
            upq   = ((m_cq >> 4) & 1) != 0;
            upn   = ctrl[4];
            pn    = 1'b0;
            for (int c = 0; c < NUM_CH; c++) begin
                if (mode_a[c] != m_mq[c] || int'(ctrl) != m_cq) begin
                    m_cnt[c] = 0;
                    m_since[c] = 0;
                    if (mode_a[c] == 1) m_st[c] = 1;
                    else if (mode_a[c] == 2) begin
                        m_st[c] = 3;
                        m_lvl[c] = upn ? 0 : code_a[c];
                    end else m_st[c] = 0;
                end else begin
                    if (m_since[c] < 99) m_since[c]++;
                    if (tk) begin
                        case (m_st[c])
                            1: begin
                                m_cnt[c]++;
                                if (m_cnt[c] >= on_l) m_st[c] = 2;
                            end
                            2: begin
                                if (m_cnt[c] + 1 >= per_l) begin m_st[c] = 1; m_cnt[c] = 0; end
                                else m_cnt[c]++;
                            end
                            3: begin
                                if (m_cnt[c] + 1 >= stp) begin
                                    m_cnt[c] = 0;
                                    if (upq) begin
                                        if (m_lvl[c] + 1 >= code_a[c]) begin m_lvl[c] = code_a[c]; m_st[c] = 4; end
                                        else m_lvl[c]++;
                                    end else begin
                                        if (m_lvl[c] <= 1) begin m_lvl[c] = 0; m_st[c] = 4; pn = 1'b1; end
                                        else m_lvl[c]--;
                                    end
                                end else m_cnt[c]++;
                            end
                            default: ;
                        endcase
                    end
                end
                m_mq[c] = mode_a[c];
            end
            m_cq = int'(ctrl);
            m_pump = pn;
        end
    end

    function automatic int exp_eff(int c);
        case (m_st[c])
            2: return 0;
            3: return m_lvl[c];
            4: return (((m_cq >> 4) & 1) != 0) ? code_a[c] : 0;
            default: return code_a[c];
        endcase
    endfunction

    function automatic string tag_of(int c);
        if (m_since[c] < 2) return "R9";
        case (m_st[c])
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return (((m_cq >> 4) & 1) != 0) ? "R6" : "R7";
        endcase
    endfunction

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            for (int c = 0; c < NUM_CH; c++) begin
                chk(eff_of(c) == exp_eff(c), tag_of(c), eff_of(c), exp_eff(c));
            end
            chk(pump == m_pump, "R8", int'(pump), int'(m_pump));
            if (pump) pump_seen++;
        end
    end

    task automatic drive_ctrl(logic [4:0] v);
        @(negedge clk); #1;
        ctrl = v;
    endtask

    initial begin
        int n;
        int e7;
        for (int c = 0; c < NUM_CH; c++) begin
            code_a[c] = (c * 7 + 3) % 64;
            mode_a[c] = 0;
        end
        code_a[8] = 63;
        code_a[9] = 0;
        repeat (4) @(negedge clk);
        // R1: reset state
        for (int c = 0; c < NUM_CH; c += 5) chk(eff_of(c) == code_a[c], "R1", eff_of(c), code_a[c]);
        chk(pump == 1'b0, "R1", int'(pump), 0);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(eff_of(17) == code_a[17], "R1", eff_of(17), code_a[17]);
        cmp_on = 1'b1;
        repeat (20) @(negedge clk);

        // Phase A: short blink, fast ramp down
        @(negedge clk); #1;
        ctrl = 5'b00000;
        for (int c = 0; c < 4; c++) mode_a[c] = 1;
        mode_a[4] = 2; mode_a[5] = 2; mode_a[8] = 2; mode_a[9] = 2;
        n = 0;
        do begin @(negedge clk); n++; end while (eff_of(0) != 0 && n < 3000);
        // R3: short on-phase of 624 ticks, within one tick of prescaler alignment
        chk(n >= 2 * 624 - 1 && n <= 2 * 624 + 2, "R3", n, 2 * 624);
        repeat (12000) @(negedge clk);

        // Phase B: long blink/period, mid ramp up
        drive_ctrl(5'b10111);
        n = 0;
        do begin @(negedge clk); n++; end while (eff_of(4) != 1 && n < 500);
        n = 0;
        do begin @(negedge clk); n++; end while (eff_of(4) != 2 && n < 500);
        // R5: step interval 30 ticks
        chk(n == 2 * 30, "R5", n, 2 * 30);
        repeat (3000) @(negedge clk);
        e7 = eff_of(7);
        @(negedge clk); #1;
        mode_a[1] = 0;
        mode_a[6] = 2;
        @(negedge clk);
        // R2: steady channel follows its code
        chk(eff_of(1) == code_a[1], "R2", eff_of(1), code_a[1]);
        // R10: neighbour untouched
        chk(eff_of(7) == e7, "R10", eff_of(7), e7);
        @(negedge clk); #1;
        mode_a[1] = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (eff_of(1) != 0 && n < 8000);
        // R9: restart gives a full long on-phase of 2500 ticks
        chk(n >= 2 * 2500 - 1 && n <= 2 * 2500 + 2, "R9", n, 2 * 2500);
        chk(eff_of(7) == e7, "R10", eff_of(7), e7);
        repeat (15000) @(negedge clk);

        // Phase C: slow ramp down; steady channel code change
        drive_ctrl(5'b01001);
        @(negedge clk); #1;
        code_a[10] = 50;
        @(negedge clk);
        chk(eff_of(10) == 50, "R2", eff_of(10), 50);
        repeat (9000) @(negedge clk);

        // Phase D: slow ramp up with select 11
        drive_ctrl(5'b11100);
        repeat (9000) @(negedge clk);

        chk(pump_seen > 0, "R8", pump_seen, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule